// File: doc/BRIEF.md
# Host Command and Status Register Port

This block is the host-facing register window of a drive controller. A host on an 8-bit bus with a two-bit address, an active-low chip select and active-low read and write strobes passes command bytes and parameter bytes to a local control CPU. It collects result bytes and status back. On the host side, writes reach a command register, a parameter queue, a write-data stub and a control register. Reads return status, the result queue, a read-data stub and queue status. The CPU has its own small register port. Through it the CPU pops parameters, pushes results, raises any of three host interrupt sources, clears the busy flag and acknowledges its own interrupt line.

The interface is synchronous to `clk`. Every clock cycle in which `hostCsN` and a strobe are both low counts as one access. The same holds for each cycle of `cpuRd` or `cpuWr`. Read data is driven combinationally from the current state while the read is active, and is 0x00 otherwise. A pop takes effect at the end of that cycle. Host control bits 0–2, 6 and 7 act as one-cycle strobes and are never stored.

Top module: `host_cmd_regs`

## Requirements
- R1: A host write to address 0 stores the byte (readable by the CPU at its address 2) and sets busy, host status bit 7, from the next cycle.
- R2: Busy stays set until the CPU writes 1 to bit 3 at CPU address 0. A command write in the same cycle as that clear leaves busy set. The CPU status at address 0 is {0, intSts[3:1], busy, resultFull, paramEmpty, cpuIrq}.
- R3: `cpuIrq` rises the cycle after a command write or a chip-reset write. It holds until the CPU writes 1 to bit 4 at CPU address 0, and a new request in the same cycle as that acknowledge wins.
- R4: Host writes to address 1 enter a 10-entry parameter queue that the CPU reads in order at its address 1. Writes to a full queue are ignored, and a CPU read of an empty queue returns 0x00.
- R5: CPU writes to its address 1 enter a 10-entry result queue that the host reads in order at address 1. A read of an empty queue returns 0x00 and disturbs nothing, and a push into a full queue is ignored.
- R6: Host address 3 reads {0000, resultFull, resultNotEmpty, paramEmpty, paramNotFull}.
- R7: A CPU write to its address 0 with bit n (n = 0..2) set sets interrupt status n+1. A host control write with bit n set clears it. If both happen in one cycle, the set wins. The statuses read in host status bits 0–2.
- R8: Each host control write loads the three interrupt enables from bits 3–5, and they read back in host status bits 3–5.
- R9: `hostIrq` is high exactly when some interrupt status and its enable are both 1.
- R10: Host status bit 6 equals the `dataReq` input in the same cycle.
- R11: A host control write with bit 6 set empties the parameter queue.
- R12: A host control write with bit 7 set empties both queues and clears busy, the statuses, the enables and the command byte. It sets `cpuIrq`, and every other action in that cycle is ignored.
- R13: Host writes to address 2 have no effect, host reads of address 2 return 0x00, and strobes while `hostCsN` is high do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostAddr | input | 2 | Host register address |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data, 0x00 when not reading |
| hostIrq | output | 1 | Host interrupt request |
| dataReq | input | 1 | Data-request level shown in host status bit 6 |
| cpuAddr | input | 2 | CPU register address |
| cpuRd | input | 1 | CPU read strobe, active high |
| cpuWr | input | 1 | CPU write strobe, active high |
| cpuWrData | input | 8 | CPU write data |
| cpuRdData | output | 8 | CPU read data, 0x00 when not reading |
| cpuIrq | output | 1 | Level interrupt request to the CPU |

## Verification
Read data, `hostIrq` and status bit 6 depend combinationally on the current state and the current inputs, so they are due in the same cycle as the read strobe. Every write, push, pop, set or clear shows in the outputs from the cycle after the clock edge that ends the access, with no further delay. The bench drives inputs just after a rising edge and samples all outputs mid-cycle. It compares them against a model that is only advanced after those samples, so each check sees exactly the state the requirements predict for that cycle.

// File: rtl/hri_pkg.sv
package hri_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 2;
  localparam int FIFO_DEPTH = 10;
  localparam int N_INT      = 3;

  localparam logic [ADDR_W-1:0] A_CMD_STS  = 2'd0;
  localparam logic [ADDR_W-1:0] A_QUEUE    = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA     = 2'd2;
  localparam logic [ADDR_W-1:0] A_CTRL_FST = 2'd3;

  typedef struct packed {
    logic             hostRd;
    logic             cpuRd;
    logic             cmdWr;
    logic             prmPush;
    logic             prmPop;
    logic             prmClr;
    logic             resPush;
    logic             resPop;
    logic             ctrlWr;
    logic             chipRst;
    logic [N_INT-1:0] stsClr;
    logic [N_INT-1:0] stsSet;
    logic [N_INT-1:0] enVal;
    logic             clrBusy;
    logic             cpuAck;
  } hriStrb_t;
endpackage

// File: rtl/hri_fifo.sv
module hri_fifo #(
  parameter int DEPTH = 10,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPush = push && !full && !clr;
  assign doPop  = pop && !empty && !clr;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R4/R5: a push into a full queue without a pop leaves the fill level alone
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !clr) |=> $stable(count));
  // R5: a pop from an empty queue leaves the read pointer alone
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !clr) |=> $stable(rdPtr));
endmodule

// File: rtl/hri_ctrl.sv
module hri_ctrl
  import hri_pkg::*;
(
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [4:0]        cpuCtlBits,
  output hriStrb_t          strb
);
  logic hostWrAct, hostRdAct, rstHit, live, cpuCtlWr;

  assign hostWrAct = !hostCsN && !hostWrN;
  assign hostRdAct = !hostCsN && !hostRdN;
  assign rstHit    = hostWrAct && (hostAddr == A_CTRL_FST) && hostWrData[7];
  assign live      = !rstHit;
  assign cpuCtlWr  = live && cpuWr && (cpuAddr == A_CMD_STS);

  always_comb begin
    strb         = '0;
    strb.hostRd  = hostRdAct;
    strb.cpuRd   = cpuRd;
    strb.chipRst = rstHit;
    strb.cmdWr   = live && hostWrAct && (hostAddr == A_CMD_STS);
    strb.prmPush = live && hostWrAct && (hostAddr == A_QUEUE);
    strb.ctrlWr  = live && hostWrAct && (hostAddr == A_CTRL_FST);
    strb.resPop  = live && hostRdAct && (hostAddr == A_QUEUE);
    strb.prmPop  = live && cpuRd && (cpuAddr == A_QUEUE);
    strb.resPush = live && cpuWr && (cpuAddr == A_QUEUE);
    if (strb.ctrlWr) begin
      strb.stsClr = hostWrData[2:0];
      strb.enVal  = hostWrData[5:3];
      strb.prmClr = hostWrData[6];
    end
    if (cpuCtlWr) begin
      strb.stsSet  = cpuCtlBits[2:0];
      strb.clrBusy = cpuCtlBits[3];
      strb.cpuAck  = cpuCtlBits[4];
    end
  end
endmodule

// File: rtl/hri_datapath.sv
module hri_datapath
  import hri_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  hriStrb_t          strb,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              dataReq,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              hostIrq,
  output logic              cpuIrq
);
  logic             busy;
  logic [N_INT-1:0] intSts, intEn;
  logic [DATA_W-1:0] cmdReg, prmHead, resHead;
  logic prmEmpty, prmFull, resEmpty, resFull;

  hri_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) prmQ_i (
    .clk(clk), .rstN(rstN), .clr(strb.chipRst || strb.prmClr),
    .push(strb.prmPush), .pop(strb.prmPop), .wrData(hostWrData),
    .head(prmHead), .empty(prmEmpty), .full(prmFull));

  hri_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) resQ_i (
    .clk(clk), .rstN(rstN), .clr(strb.chipRst),
    .push(strb.resPush), .pop(strb.resPop), .wrData(cpuWrData),
    .head(resHead), .empty(resEmpty), .full(resFull));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cpuIrq <= 1'b0;
      intSts <= '0;
      intEn  <= '0;
      cmdReg <= '0;
    end else if (strb.chipRst) begin
      busy   <= 1'b0;
      cpuIrq <= 1'b1;
      intSts <= '0;
      intEn  <= '0;
      cmdReg <= '0;
    end else begin
      busy   <= strb.cmdWr || (busy && !strb.clrBusy);
      cpuIrq <= strb.cmdWr || (cpuIrq && !strb.cpuAck);
      intSts <= (intSts & ~strb.stsClr) | strb.stsSet;
      if (strb.ctrlWr) intEn  <= strb.enVal;
      if (strb.cmdWr)  cmdReg <= hostWrData;
    end
  end

  assign hostIrq = |(intSts & intEn);

  always_comb begin
    hostRdData = '0;
    if (strb.hostRd) begin
      unique case (hostAddr)
        A_CMD_STS:  hostRdData = {busy, dataReq, intEn, intSts};
        A_QUEUE:    hostRdData = resEmpty ? '0 : resHead;
        A_DATA:     hostRdData = '0;
        A_CTRL_FST: hostRdData = {4'b0000, resFull, !resEmpty, prmEmpty, !prmFull};
        default:    hostRdData = '0;
      endcase
    end
  end

  always_comb begin
    cpuRdData = '0;
    if (strb.cpuRd) begin
      unique case (cpuAddr)
        A_CMD_STS:  cpuRdData = {1'b0, intSts, busy, resFull, prmEmpty, cpuIrq};
        A_QUEUE:    cpuRdData = prmEmpty ? '0 : prmHead;
        A_DATA:     cpuRdData = cmdReg;
        default:    cpuRdData = '0;
      endcase
    end
  end

  a_r1_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmdWr |=> busy);
  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.clrBusy && !strb.chipRst) |=> busy);
  a_r3_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cpuIrq && !strb.cpuAck) |=> cpuIrq);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stsSet != '0) |=> ((intSts & $past(strb.stsSet)) == $past(strb.stsSet)));
  a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(prmFull && prmEmpty) && !(resFull && resEmpty));
  a_r12_chip_reset: assert property (@(posedge clk) disable iff (!rstN)
    strb.chipRst |=> (cpuIrq && !busy && intSts == '0 && intEn == '0 && prmEmpty && resEmpty));
endmodule

// File: rtl/host_cmd_regs.sv
module host_cmd_regs
  import hri_pkg::*;
#(
  parameter int DEPTH = FIFO_DEPTH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              hostIrq,
  input  logic              dataReq,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuIrq
);
  hriStrb_t strb;

  hri_ctrl ctrl_i (
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostAddr(hostAddr), .hostWrData(hostWrData),
    .cpuAddr(cpuAddr), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .cpuCtlBits(cpuWrData[4:0]), .strb(strb));

  hri_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostAddr(hostAddr), .hostWrData(hostWrData),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .dataReq(dataReq),
    .hostRdData(hostRdData), .cpuRdData(cpuRdData),
    .hostIrq(hostIrq), .cpuIrq(cpuIrq));
endmodule

// File: tb/host_cmd_regs_tb_top.sv
module host_cmd_regs_tb_top;
  localparam int QD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic hostIrq, dataReq = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic cpuRd = 1'b0, cpuWr = 1'b0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic cpuIrq;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  string phase = "reset";

  // bench model
  logic [7:0] mPrm[$];
  logic [7:0] mRes[$];
  logic mBusy = 1'b0, mIrq = 1'b0;
  logic [2:0] mSts = '0, mEn = '0;
  logic [7:0] mCmd = '0;

  always #4 clk = ~clk;

  host_cmd_regs dut_i (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .hostIrq(hostIrq), .dataReq(dataReq), .cpuAddr(cpuAddr), .cpuRd(cpuRd),
    .cpuWr(cpuWr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuIrq(cpuIrq));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s (%s): got %02h expected %02h", tag, phase, act, exp);
    end
  endtask

  function automatic logic [7:0] expHost();
    if (hostCsN || hostRdN) return 8'h00;
    case (hostAddr)
      2'd0: return {mBusy, dataReq, mEn, mSts};
      2'd1: return (mRes.size() == 0) ? 8'h00 : mRes[0];
      2'd2: return 8'h00;
      default: return {4'b0, mRes.size() == QD, mRes.size() != 0,
                       mPrm.size() == 0, mPrm.size() != QD};
    endcase
  endfunction

  function automatic logic [7:0] expCpu();
    if (!cpuRd) return 8'h00;
    case (cpuAddr)
      2'd0: return {1'b0, mSts, mBusy, mRes.size() == QD, mPrm.size() == 0, mIrq};
      2'd1: return (mPrm.size() == 0) ? 8'h00 : mPrm[0];
      2'd2: return mCmd;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string hostTag();
    case (hostAddr)
      2'd0: return "R7";
      2'd1: return "R5";
      2'd2: return "R13";
      default: return "R6";
    endcase
  endfunction

  function automatic string cpuTag();
    case (cpuAddr)
      2'd0: return "R2";
      2'd1: return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic modelUpdate();
    bit hw, hr, cmd, ctl, cpuCtl;
    hw = !hostCsN && !hostWrN;
    hr = !hostCsN && !hostRdN;
    if (hw && hostAddr == 2'd3 && hostWrData[7]) begin
      mPrm.delete(); mRes.delete();
      mBusy = 0; mSts = 0; mEn = 0; mCmd = 0; mIrq = 1;
      return;
    end
    cmd = hw && hostAddr == 2'd0;
    ctl = hw && hostAddr == 2'd3;
    cpuCtl = cpuWr && cpuAddr == 2'd0;
    mIrq  = cmd || (mIrq && !(cpuCtl && cpuWrData[4]));
    mBusy = cmd || (mBusy && !(cpuCtl && cpuWrData[3]));
    mSts  = (mSts & ~(ctl ? hostWrData[2:0] : 3'b0)) | (cpuCtl ? cpuWrData[2:0] : 3'b0);
    if (ctl) mEn = hostWrData[5:3];
    if (cmd) mCmd = hostWrData;
    if (ctl && hostWrData[6]) mPrm.delete();
    else begin
      bit popP;
      popP = cpuRd && cpuAddr == 2'd1 && mPrm.size() != 0;
      if (hw && hostAddr == 2'd1 && mPrm.size() < QD) mPrm.push_back(hostWrData);
      if (popP) void'(mPrm.pop_front());
    end
    begin
      bit popR;
      popR = hr && hostAddr == 2'd1 && mRes.size() != 0;
      if (cpuWr && cpuAddr == 2'd1 && mRes.size() < QD) mRes.push_back(cpuWrData);
      if (popR) void'(mRes.pop_front());
    end
  endtask

  // inputs already driven just after a rising edge; sample mid-cycle, then advance
  task automatic step();
    @(negedge clk);
    #1;
    check(hostTag(), hostRdData, expHost());
    check(cpuTag(), cpuRdData, expCpu());
    check("R9", {7'b0, hostIrq}, {7'b0, |(mSts & mEn)});
    check("R3", {7'b0, cpuIrq}, {7'b0, mIrq});
    modelUpdate();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    hostCsN = 1; hostRdN = 1; hostWrN = 1; cpuRd = 0; cpuWr = 0;
  endtask

  task automatic hw(logic [1:0] a, logic [7:0] d);
    hostCsN = 0; hostWrN = 0; hostAddr = a; hostWrData = d; step(); idle();
  endtask
  task automatic hr(logic [1:0] a);
    hostCsN = 0; hostRdN = 0; hostAddr = a; step(); idle();
  endtask
  task automatic cw(logic [1:0] a, logic [7:0] d);
    cpuWr = 1; cpuAddr = a; cpuWrData = d; step(); idle();
  endtask
  task automatic cr(logic [1:0] a);
    cpuRd = 1; cpuAddr = a; step(); idle();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1357);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // reset state: status 0, fifo status 0x03 (R6)
    hr(2'd0); hr(2'd3); cr(2'd0);

    phase = "R13 stubs and deselect";
    hostCsN = 1; hostWrN = 0; hostAddr = 2'd0; hostWrData = 8'hAA; step(); idle();
    hw(2'd2, 8'h55); hr(2'd2); hr(2'd0); cr(2'd2);

    phase = "R1 R2 R3 command and busy";
    hw(2'd0, 8'h3C); hr(2'd0); cr(2'd2); cr(2'd0);
    cw(2'd0, 8'h10); cr(2'd0);              // ack irq
    cw(2'd0, 8'h08); hr(2'd0);              // clear busy
    hw(2'd0, 8'h11); // busy set again
    hostCsN = 0; hostWrN = 0; hostAddr = 2'd0; hostWrData = 8'h22;
    cpuWr = 1; cpuAddr = 2'd0; cpuWrData = 8'h18; step(); idle();   // set wins
    hr(2'd0); cr(2'd0); cw(2'd0, 8'h18); hr(2'd0);

    phase = "R4 parameter queue fill and drain";
    for (int i = 0; i < QD + 2; i++) hw(2'd1, 8'h40 + 8'(i));
    hr(2'd3);
    for (int i = 0; i < QD + 2; i++) cr(2'd1);
    hr(2'd3);

    phase = "R5 result queue fill and drain";
    hr(2'd1);
    for (int i = 0; i < QD + 1; i++) cw(2'd1, 8'h80 + 8'(i));
    hr(2'd3); cr(2'd0);
    for (int i = 0; i < QD + 2; i++) hr(2'd1);
    hr(2'd3);

    phase = "R7 R8 R9 R10 interrupts";
    cw(2'd0, 8'h07); hr(2'd0);
    hw(2'd3, 8'b00_101_000); hr(2'd0);
    hw(2'd3, 8'b00_101_001); hr(2'd0);
    hostCsN = 0; hostWrN = 0; hostAddr = 2'd3; hostWrData = 8'b00_111_110;
    cpuWr = 1; cpuAddr = 2'd0; cpuWrData = 8'h02; step(); idle();
    hr(2'd0);
    dataReq = 1; hr(2'd0); dataReq = 0; hr(2'd0);

    phase = "R11 parameter clear";
    hw(2'd1, 8'h01); hw(2'd1, 8'h02); hr(2'd3);
    hw(2'd3, 8'h40); hr(2'd3); cr(2'd1); hr(2'd0);

    phase = "R12 chip reset";
    hw(2'd1, 8'h09); cw(2'd1, 8'h0A); hw(2'd0, 8'h77); cw(2'd0, 8'h10);
    hostCsN = 0; hostWrN = 0; hostAddr = 2'd3; hostWrData = 8'b1111_1000;
    cpuWr = 1; cpuAddr = 2'd0; cpuWrData = 8'h07; step(); idle();
    hr(2'd0); hr(2'd3); cr(2'd0); cr(2'd2);

    phase = "random";
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom % 8;
      dataReq = 1'($urandom);
      hostAddr = 2'($urandom); hostWrData = 8'($urandom);
      if (hostAddr == 2'd3 && ($urandom % 16) != 0) hostWrData[7] = 1'b0;
      hostCsN = (op == 0); hostWrN = !(op inside {1, 2, 3}); hostRdN = !(op inside {4, 5, 6});
      cpuAddr = 2'($urandom); cpuWrData = 8'($urandom);
      cpuWr = ($urandom % 3) == 0; cpuRd = !cpuWr && (($urandom % 2) == 0);
      step(); idle();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule